// File: doc/BRIEF.md
# Register-Programmed SPI Master with Core-State Control

This block is a serial peripheral master that moves 8-bit words between two on-chip FIFOs and the serial pins. Software talks to it through a small register port. It pushes bytes into a transmit FIFO, chooses the clock polarity, the sampling phase and the clock divider, and then moves the core into its run state. In the run state the core shifts out one word for each byte in the transmit FIFO and places each received word in a receive FIFO, from which software pops it one byte at a time. Chip select is not part of the block; software drives it as an ordinary pin.

Software moves the core between three states: reset, run and pause. A state-valid flag gates every state change. Moving into the reset state empties both FIFOs and clears the progress counters. Two 16-bit limit registers bound a transfer. A nonzero transmit limit stops new words once that many have been started. A nonzero receive limit stops receive-FIFO writes once that many words have arrived. A limit of zero means no limit. To read from a device, software programs the same length into both limits and writes that many 0xFF dummy bytes. Writing 1 to the soft-reset register returns the whole core to its reset values.

The register port is a plain control interface with no handshake. A write takes effect on the clock edge that samples it. A read returns data combinationally, and a read of the receive data address with `reg_rd` high pops that FIFO on the same edge. The block never stalls the register port: writes to a full FIFO are discarded.

Top module: `spim_core`

Register map (addresses on `reg_addr`; fields not listed read as 0):

| Address | Name | Fields |
|---|---|---|
| 0 | state | bits 1:0 state code, bit 2 state-valid flag (read only) |
| 1 | mode | bit 0 sample-first, bit 1 idle-high |
| 2 | pin control | bit 0 drive-always |
| 3 | flags | bit 0 transmit full, bit 1 transmit not empty, bit 2 receive not empty (read only) |
| 4 | transmit data | write pushes the low 8 bits |
| 5 | receive data | oldest byte in the low 8 bits; read with `reg_rd` high pops it |
| 6 | transmit limit | 16 bits |
| 7 | receive limit | 16 bits |
| 8 | clock divider | 8 bits |
| 9 | soft reset | write 1 to bit 0 |

## Requirements
- R1: After reset the state register (address 0) reads 4: state code 0 (reset) with the valid flag in bit 2 set. The flags register (address 3) reads 0, `sclk` is low and `mosi_oe` is low.
- R2: A write to the state register is accepted only while the valid flag is 1 and the code is 0 (reset), 1 (run) or 2 (pause). In the cycle after an accepted write the flag reads 0, and in the next cycle it reads 1 again. A write made while the flag is 0, or a write of code 3, changes nothing.
- R3: Each word produces exactly 16 `sclk` edges, and each half-period lasts divider+1 clock cycles. Data is sent MSB first. Mode bit 1 sets the idle level of `sclk`. When mode bit 0 is 1, `miso` is sampled on leading edges and `mosi` changes on trailing edges. When mode bit 0 is 0, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R4: A word starts only in the run state. In the pause state the word already in progress finishes, no new word starts, and the FIFO contents are kept. Returning to run resumes the transfer.
- R5: With a nonzero transmit limit N, no word starts once N words have started since the core entered the reset state. A limit of 0 is unlimited.
- R6: With a nonzero receive limit N, only the first N received words are written to the receive FIFO. A limit of 0 is unlimited.
- R7: Entering the reset state empties both FIFOs and clears the started and received word counts. The limit, mode, divider and pin-control registers keep their values.
- R8: Each FIFO holds 16 entries. A write to a full transmit FIFO is discarded, and so is a word received while the receive FIFO is full. The flags register has bit 0 set when the transmit FIFO is full, bit 1 when the transmit FIFO is not empty, and bit 2 when the receive FIFO is not empty.
- R9: A read of the receive data address returns the oldest received byte in bits 7:0. When `reg_rd` is high, that byte is removed from the FIFO.
- R10: Writing 1 to bit 0 of address 9 returns every register to its reset value and empties both FIFOs.
- R11: When pin-control bit 0 is 1, `mosi_oe` is 1 at all times. When it is 0, `mosi_oe` is 1 only while a word is being shifted.
- R12: `sclk` rests at its idle level between words and toggles only while a word is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The assertions check four things on every cycle: the one-cycle drop and recovery of the valid flag around an accepted state change, that words begin only after a cycle in the run state, that both FIFOs and counts are empty right after the core enters reset, and that every completed word has produced exactly 16 clock edges. The FIFOs also carry a check that a push to a full FIFO leaves the occupancy unchanged. The bench sweeps all four polarity and phase modes against three divider values and compares the data at both ends with a byte-level device model. Only these scenarios can show the bit order, the half-period length, the limit stops, the pause and resume behaviour, the FIFO overflow drops and the effect of the soft reset.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } core_state_e;

  localparam logic [3:0] A_STATE = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_PINS  = 4'd2;
  localparam logic [3:0] A_FLAGS = 4'd3;
  localparam logic [3:0] A_TXD   = 4'd4;
  localparam logic [3:0] A_RXD   = 4'd5;
  localparam logic [3:0] A_TXLIM = 4'd6;
  localparam logic [3:0] A_RXLIM = 4'd7;
  localparam logic [3:0] A_DIV   = 4'd8;
  localparam logic [3:0] A_SRST  = 4'd9;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  // R8: a push into a full FIFO leaves occupancy unchanged
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              cpol,
  input  logic              sample_first,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [DIV_W-1:0]  hcnt;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              tick, leading, last_edge, sample_now, shift_now;

  assign tick       = busy && (hcnt == div);
  assign leading    = !edge_q[0];
  assign last_edge  = (edge_q == EW'(EDGES - 1));
  assign sample_now = tick && (leading == sample_first);
  assign shift_now  = tick && (leading != sample_first) && !last_edge;
  assign rx_word    = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      hcnt   <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
      sclk <= cpol;
      hcnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk   <= cpol;
        hcnt   <= '0;
        edge_q <= '0;
        if (start) begin
          busy <= 1'b1;
          if (sample_first) begin
            mosi  <= tx_word[DATA_W-1];
            tx_sh <= tx_word << 1;
          end else begin
            tx_sh <= tx_word;
          end
        end
      end else begin
        if (tick) begin
          hcnt   <= '0;
          sclk   <= ~sclk;
          edge_q <= edge_q + 1'b1;
          if (last_edge) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
        if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        if (shift_now) begin
          mosi  <= tx_sh[DATA_W-1];
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  // checker: count clock edges within the word
  logic [EW:0] chk_tog;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_tog <= '0;
    else if (!busy) chk_tog <= '0;
    else if (tick)  chk_tog <= chk_tog + 1'b1;
  end

  // R3: every completed word produced exactly 2*DATA_W edges
  p_word_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_tog == (EW+1)'(EDGES)));
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             sclk,
  output logic             mosi,
  output logic             mosi_oe,
  input  logic             miso
);
  core_state_e       state_q, st_req;
  logic              valid_q, sample_first, idle_high, drive_always;
  logic [CNT_W-1:0]  tx_lim, rx_lim, tx_sent, rx_got;
  logic [DIV_W-1:0]  div_q;

  logic              clr, st_ok, enter_reset, flush;
  logic              tx_push, rx_pop, start, rx_take, tx_stop, rx_stop;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              busy, done;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;

  assign clr         = reg_wr && (reg_addr == A_SRST) && reg_wdata[0];
  assign st_req      = core_state_e'(reg_wdata[1:0]);
  assign st_ok       = reg_wr && (reg_addr == A_STATE) && valid_q && (reg_wdata[1:0] != 2'b11);
  assign enter_reset = st_ok && (st_req == ST_RESET);
  assign flush       = clr || enter_reset;
  assign tx_push     = reg_wr && (reg_addr == A_TXD);
  assign rx_pop      = reg_rd && (reg_addr == A_RXD);
  assign tx_stop     = (tx_lim != '0) && (tx_sent == tx_lim);
  assign rx_stop     = (rx_lim != '0) && (rx_got == rx_lim);
  assign start       = (state_q == ST_RUN) && !busy && !tx_empty && !tx_stop;
  assign rx_take     = done && !rx_stop;
  assign mosi_oe     = drive_always || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET; valid_q <= 1'b1;
      sample_first <= 1'b0; idle_high <= 1'b0; drive_always <= 1'b0;
      tx_lim <= '0; rx_lim <= '0; div_q <= '0;
    end else if (clr) begin
      state_q <= ST_RESET; valid_q <= 1'b1;
      sample_first <= 1'b0; idle_high <= 1'b0; drive_always <= 1'b0;
      tx_lim <= '0; rx_lim <= '0; div_q <= '0;
    end else begin
      if (st_ok) begin
        state_q <= st_req;
        valid_q <= 1'b0;
      end else begin
        valid_q <= 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr)
          A_MODE:  begin sample_first <= reg_wdata[0]; idle_high <= reg_wdata[1]; end
          A_PINS:  drive_always <= reg_wdata[0];
          A_TXLIM: tx_lim <= reg_wdata;
          A_RXLIM: rx_lim <= reg_wdata;
          A_DIV:   div_q <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sent <= '0;
      rx_got  <= '0;
    end else if (flush) begin
      tx_sent <= '0;
      rx_got  <= '0;
    end else begin
      if (start)   tx_sent <= tx_sent + 1'b1;
      if (rx_take) rx_got  <= rx_got + 1'b1;
    end
  end

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push),
    .din(reg_wdata[DATA_W-1:0]), .pop(start), .dout(tx_head),
    .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_take),
    .din(rx_word), .pop(rx_pop), .dout(rx_head),
    .full(rx_full), .empty(rx_empty));

  spim_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(flush), .start(start), .tx_word(tx_head),
    .cpol(idle_high), .sample_first(sample_first), .div(div_q), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word));

  always_comb begin
    case (reg_addr)
      A_STATE: reg_rdata = CNT_W'({valid_q, state_q});
      A_MODE:  reg_rdata = CNT_W'({idle_high, sample_first});
      A_PINS:  reg_rdata = CNT_W'(drive_always);
      A_FLAGS: reg_rdata = CNT_W'({!rx_empty, !tx_empty, tx_full});
      A_RXD:   reg_rdata = CNT_W'(rx_head);
      A_TXLIM: reg_rdata = tx_lim;
      A_RXLIM: reg_rdata = rx_lim;
      A_DIV:   reg_rdata = CNT_W'(div_q);
      default: reg_rdata = '0;
    endcase
  end

  // R2: valid flag drops for exactly one cycle after an accepted change
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ok && !clr) |=> !valid_q);
  p_valid_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |=> valid_q);
  // R4: the shift engine only leaves idle after a cycle in the run state
  p_run_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state_q) == ST_RUN));
  // R7: entering reset leaves both FIFOs and both counts empty
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_reset |=> (tx_empty && rx_empty && tx_sent == '0 && rx_got == '0));
endmodule

// File: tb/test_spim_core.sv
module test_spim_core;
  localparam logic [3:0] S_ST = 4'd0, S_MODE = 4'd1, S_PINS = 4'd2, S_FLG = 4'd3,
                         S_TXD = 4'd4, S_RXD = 4'd5, S_TXL = 4'd6, S_RXL = 4'd7,
                         S_DIV = 4'd8, S_SR = 4'd9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        sclk, mosi, mosi_oe, miso;
  logic        miso_r = 1'b0;

  always #5 clk = ~clk;
  assign miso = miso_r;

  spim_core i_spim_core (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .mosi_oe(mosi_oe), .miso(miso));

  int nchk = 0, nfail = 0;
  bit fin = 1'b0;

  // device model state
  bit         s_cpol = 1'b0, s_sf = 1'b0;
  int         s_tbits = 0, s_rbits = 0, tog = 0, gap1 = 0, last_cyc = 0, cyc = 0;
  logic [7:0] s_rx = '0, b = '0;
  logic [7:0] got [64];
  logic       sclk_prev = 1'b0;

  function automatic logic [7:0] sbyte(int k);
    return 8'((150 + k * 53) % 256);
  endfunction

  function automatic logic [7:0] txb(int m, int d, int k);
    return 8'h5A ^ 8'((k * 17) % 256) ^ 8'(m * 3 + d);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && (sclk !== sclk_prev)) begin
      tog++;
      if (tog == 2) gap1 = cyc - last_cyc;
      last_cyc = cyc;
      if ((sclk != s_cpol) == s_sf) begin
        s_rx = {s_rx[6:0], mosi};
        s_rbits++;
        if (s_rbits % 8 == 0) got[(s_rbits / 8 - 1) % 64] = s_rx;
      end else begin
        b = sbyte(s_tbits / 8);
        miso_r = b[7 - (s_tbits % 8)];
        s_tbits++;
      end
    end
    sclk_prev = sclk;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit pop, output logic [15:0] d);
    reg_addr = a; reg_rd = pop;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slave_reset(input bit sf, input bit cpol);
    s_sf = sf; s_cpol = cpol; s_rbits = 0; s_tbits = 0; tog = 0; gap1 = 0;
    sclk_prev = sclk;
    if (sf) begin
      b = sbyte(0);
      miso_r = b[7];
      s_tbits = 1;
    end
  endtask

  logic [15:0] v;

  initial begin
    waitn(3);
    rst_n = 1'b1;
    step();
    // R1 reset values
    rd(S_ST, 0, v);   chk("R1 state", v, 16'h4);
    rd(S_FLG, 0, v);  chk("R1 flags", v, 16'h0);
    chk("R1 sclk", sclk, 1'b0);
    chk("R1 oe", mosi_oe, 1'b0);

    // R2 valid handshake
    wr(S_ST, 16'd1);
    rd(S_ST, 0, v);   chk("R2 valid low", v, 16'h1);
    rd(S_ST, 0, v);   chk("R2 valid back", v, 16'h5);
    wr(S_ST, 16'd2);
    wr(S_ST, 16'd0);  // ignored: valid low
    rd(S_ST, 0, v);   chk("R2 write while invalid", v, 16'h6);
    wr(S_ST, 16'd3);
    rd(S_ST, 0, v);   chk("R2 code 3 ignored", v, 16'h6);
    wr(S_ST, 16'd0);
    step();

    // R3/R12/R9 sweep over modes and dividers
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 3; di++) begin
        int d;
        bit sf, cp;
        d  = (di == 2) ? 3 : di;
        sf = (m % 2 == 0);
        cp = (m >= 2);
        wr(S_ST, 16'd0);
        wr(S_MODE, 16'({cp, sf}));
        wr(S_DIV, 16'(d));
        wr(S_TXL, 16'd0);
        wr(S_RXL, 16'd0);
        for (int k = 0; k < 5; k++) wr(S_TXD, 16'(txb(m, d, k)));
        step();
        slave_reset(sf, cp);
        chk("R3 idle level before run", sclk, cp);
        wr(S_ST, 16'd1);
        step(); step();
        chk("R11 oe while shifting", mosi_oe, 1'b1);
        waitn(5 * (16 * (d + 1) + 2) + 20);
        chk("R12 edge total", tog, 80);
        chk("R3 half period", gap1, d + 1);
        chk("R12 idle after", sclk, cp);
        chk("R11 oe idle", mosi_oe, 1'b0);
        for (int k = 0; k < 5; k++) begin
          rd(S_RXD, 1, v);
          chk("R9 rx byte", v, 16'(sbyte(k)));
          chk("R3 device got", got[k], txb(m, d, k));
        end
        rd(S_FLG, 0, v);  chk("R9 rx drained", v, 16'h0);
      end
    end

    // R4 pause
    wr(S_ST, 16'd0);
    wr(S_MODE, 16'd1);
    wr(S_DIV, 16'd3);
    for (int k = 0; k < 4; k++) wr(S_TXD, 16'(k + 1));
    step();
    slave_reset(1, 0);
    wr(S_ST, 16'd1);
    waitn(10);
    wr(S_ST, 16'd2);
    waitn(300);
    chk("R4 one word in pause", tog, 16);
    rd(S_FLG, 0, v);  chk("R4 fifo kept", v, 16'h6);
    wr(S_ST, 16'd1);
    waitn(300);
    chk("R4 resumed", tog, 64);
    for (int k = 0; k < 4; k++) begin
      rd(S_RXD, 1, v);
      chk("R4 rx data", v, 16'(sbyte(k)));
    end

    // R5 transmit limit
    wr(S_ST, 16'd0);
    wr(S_DIV, 16'd0);
    wr(S_TXL, 16'd3);
    for (int k = 0; k < 6; k++) wr(S_TXD, 16'(k));
    step();
    slave_reset(1, 0);
    wr(S_ST, 16'd1);
    waitn(300);
    chk("R5 stop at limit", tog, 48);
    rd(S_FLG, 0, v);  chk("R5 flags", v, 16'h6);

    // R7 reset entry flushes and restarts the count
    wr(S_ST, 16'd0);
    rd(S_FLG, 0, v);  chk("R7 flushed", v, 16'h0);
    rd(S_TXL, 0, v);  chk("R7 limit kept", v, 16'd3);
    for (int k = 0; k < 4; k++) wr(S_TXD, 16'(k));
    step();
    slave_reset(1, 0);
    wr(S_ST, 16'd1);
    waitn(300);
    chk("R7 count restarted", tog, 48);

    // R6 receive limit
    wr(S_ST, 16'd0);
    wr(S_TXL, 16'd0);
    wr(S_RXL, 16'd2);
    for (int k = 0; k < 4; k++) wr(S_TXD, 16'(k));
    step();
    slave_reset(1, 0);
    wr(S_ST, 16'd1);
    waitn(300);
    chk("R6 all sent", tog, 64);
    rd(S_RXD, 1, v);  chk("R6 rx0", v, 16'(sbyte(0)));
    rd(S_RXD, 1, v);  chk("R6 rx1", v, 16'(sbyte(1)));
    rd(S_FLG, 0, v);  chk("R6 only two stored", v, 16'h0);

    // R8 FIFO depth and drops
    wr(S_ST, 16'd0);
    wr(S_RXL, 16'd0);
    for (int k = 0; k < 17; k++) wr(S_TXD, 16'(k));
    rd(S_FLG, 0, v);  chk("R8 tx full flag", v, 16'h3);
    step();
    slave_reset(1, 0);
    wr(S_ST, 16'd1);
    waitn(400);
    chk("R8 extra write dropped", tog, 256);
    wr(S_TXD, 16'd7);
    wr(S_TXD, 16'd8);
    waitn(100);
    chk("R8 two more sent", tog, 288);
    for (int k = 0; k < 16; k++) begin
      rd(S_RXD, 1, v);
      chk("R8 rx kept", v, 16'(sbyte(k)));
    end
    rd(S_FLG, 0, v);  chk("R8 overflow dropped", v, 16'h0);

    // R11 drive-always
    wr(S_PINS, 16'd1);
    step();
    chk("R11 oe forced", mosi_oe, 1'b1);

    // R10 soft reset
    wr(S_MODE, 16'd3);
    wr(S_DIV, 16'd5);
    wr(S_TXL, 16'd7);
    wr(S_ST, 16'd0);
    wr(S_TXD, 16'd1);
    wr(S_SR, 16'd1);
    step();
    rd(S_ST, 0, v);   chk("R10 state", v, 16'h4);
    rd(S_MODE, 0, v); chk("R10 mode", v, 16'h0);
    rd(S_DIV, 0, v);  chk("R10 div", v, 16'h0);
    rd(S_TXL, 0, v);  chk("R10 limit", v, 16'h0);
    rd(S_PINS, 0, v); chk("R10 pins", v, 16'h0);
    rd(S_FLG, 0, v);  chk("R10 flags", v, 16'h0);
    chk("R10 oe", mosi_oe, 1'b0);

    if (!fin) begin
      fin = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule